// File: doc/BRIEF.md
# Granular memory protection region checker

This block watches a stream of bus access addresses and decides, one access at a time, whether each one is allowed by a small table of protection windows. Each window holds an enable flag and a write-allowed flag. Its two boundaries are stored only to 8-byte resolution. The three low address bits of a boundary cannot be programmed. When the checker compares an address, it fills the missing low bits of a window start with zeros and the missing low bits of a window end with ones. Each window therefore covers whole 8-byte blocks, and both ends are inclusive.

Software, or a configuration controller, loads a window through a simple write port. The port gives the window index, both boundaries, the enable flag and the write-allowed flag. The access port carries a valid strobe, a 23-bit address and a write flag.

A registered violation flag follows each access by one clock. The flag is raised in two cases:
- the address lies in no enabled window;
- the access is a write and every window that holds the address forbids writes.

Reads are allowed in any enabled window.

Top module: `prot_window_check`

## Requirements
- R1: A synchronous reset disables all windows and drives `viol` low. After reset, `viol` stays low until a valid access is presented.
- R2: `viol` is registered. It reflects the access presented in the previous cycle. It is low in any cycle that follows a cycle with `acc_valid` low.
- R3: A window start is compared as the stored start value shifted left by 3 with zeros in bits [2:0]. The comparison is unsigned and inclusive.
- R4: A window end is compared as the stored end value shifted left by 3 with ones in bits [2:0]. The comparison is unsigned and inclusive. A start of 0 with an end of 0 covers addresses 0 through 7. An end value of 0x13F888>>3 covers addresses up to 0x13F88F.
- R5: A valid access, read or write, whose address lies in no enabled window raises `viol`.
- R6: A valid write whose address lies only in windows whose write-allowed flag is 0 raises `viol`. A read to the same address does not raise `viol`.
- R7: Where windows overlap, a write is allowed if at least one enabled window holding the address allows writes.
- R8: A window whose stored start is greater than its stored end matches no address.
- R9: A window whose enable flag is 0 has no effect on any access.
- R10: A window write with `cfg_we` high takes effect for an access presented in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for one window |
| cfg_idx | input | 2 | Index of the window being written |
| cfg_lo | input | 20 | Window start, address bits [22:3] |
| cfg_hi | input | 20 | Window end, address bits [22:3] |
| cfg_en | input | 1 | Window enable flag |
| cfg_wr_ok | input | 1 | Window write-allowed flag |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 23 | Access byte address |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| viol | output | 1 | Registered violation flag for the previous cycle's access |

## Verification
The checker has one register between the access inputs and `viol`, so each verdict appears exactly one clock after its access. The bench drives every access on a falling edge. It samples `viol` on the next falling edge, after the capturing rising edge. Window writes are applied the same way. The first access after a write is presented on the falling edge that ends the write cycle, so that access checks that the new settings are already in force. The bench sweeps every address around each window boundary, as both a read and a write, and compares the result with an arithmetic model of the padded boundaries. An idle cycle is checked for a low flag.

// File: rtl/prot_window_check.sv
module prot_window_check #(
  parameter int ADDR_W   = 23,
  parameter int GRAN_BITS = 3,
  parameter int NUM_WIN  = 4,
  localparam int BND_W   = ADDR_W - GRAN_BITS,
  localparam int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [BND_W-1:0]  cfg_lo,
  input  logic [BND_W-1:0]  cfg_hi,
  input  logic              cfg_en,
  input  logic              cfg_wr_ok,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              viol
);

  logic [BND_W-1:0]   lo_q [NUM_WIN];
  logic [BND_W-1:0]   hi_q [NUM_WIN];
  logic [NUM_WIN-1:0] en_q;
  logic [NUM_WIN-1:0] wok_q;
  logic [NUM_WIN-1:0] hit;
  logic [NUM_WIN-1:0] wr_hit;
  logic               fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      wok_q <= '0;
    end else if (cfg_we) begin
      en_q[cfg_idx]  <= cfg_en;
      wok_q[cfg_idx] <= cfg_wr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      lo_q[cfg_idx] <= cfg_lo;
      hi_q[cfg_idx] <= cfg_hi;
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [ADDR_W-1:0] lo_full, hi_full;
    assign lo_full   = {lo_q[i], {GRAN_BITS{1'b0}}};
    assign hi_full   = {hi_q[i], {GRAN_BITS{1'b1}}};
    assign hit[i]    = en_q[i] && (acc_addr >= lo_full) && (acc_addr <= hi_full);
    assign wr_hit[i] = hit[i] && wok_q[i];

    a_r8_empty_window: assert property (@(posedge clk) disable iff (rst)
      hit[i] |-> (lo_q[i] <= hi_q[i]));
  end

  assign fault = (hit == '0) || (acc_write && (wr_hit == '0));

  always_ff @(posedge clk) begin
    if (rst) viol <= 1'b0;
    else     viol <= acc_valid && fault;
  end

  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> !viol);

  a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> !viol);

  a_r5_no_window: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid && (hit == '0)) |-> viol);

  a_r6_read_only: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid && acc_write && (hit != '0) && (wr_hit == '0)) |-> viol);

  a_r7_allowed: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid && (wr_hit != '0)) |-> !viol);

endmodule

// File: tb/test_prot_window_check.sv
module test_prot_window_check;
  localparam int CLK_P = 10;
  localparam int AW = 23;
  localparam int BW = 20;
  localparam int NW = 4;

  logic clk = 0;
  logic rst = 1;
  logic cfg_we = 0;
  logic [1:0] cfg_idx = 0;
  logic [BW-1:0] cfg_lo = 0, cfg_hi = 0;
  logic cfg_en = 0, cfg_wr_ok = 0;
  logic acc_valid = 0;
  logic [AW-1:0] acc_addr = 0;
  logic acc_write = 0;
  logic viol;

  int total = 0;
  int bad = 0;

  logic [BW-1:0] m_lo [NW];
  logic [BW-1:0] m_hi [NW];
  logic m_en [NW];
  logic m_wok [NW];

  always #(CLK_P/2) clk = ~clk;

  prot_window_check i_prot_window_check (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_en(cfg_en), .cfg_wr_ok(cfg_wr_ok),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
    .viol(viol)
  );

  function automatic logic model(input logic [AW-1:0] a, input logic w);
    logic any_hit = 0;
    logic any_wr = 0;
    for (int i = 0; i < NW; i++) begin
      longint lo = longint'(m_lo[i]) * 8;
      longint hi = longint'(m_hi[i]) * 8 + 7;
      if (m_en[i] && longint'(a) >= lo && longint'(a) <= hi) begin
        any_hit = 1;
        if (m_wok[i]) any_wr = 1;
      end
    end
    return !any_hit || (w && !any_wr);
  endfunction

  task automatic check(input logic exp, input string tag);
    total++;
    if (viol !== exp) begin
      bad++;
      $display("FAIL %s addr=%h wr=%0b viol=%b expected=%b", tag, acc_addr, acc_write, viol, exp);
    end
  endtask

  task automatic set_win(input int idx, input int lo, input int hi, input logic en, input logic wok);
    @(negedge clk);
    acc_valid = 0;
    cfg_we = 1; cfg_idx = 2'(idx); cfg_lo = BW'(lo); cfg_hi = BW'(hi);
    cfg_en = en; cfg_wr_ok = wok;
    m_lo[idx] = BW'(lo); m_hi[idx] = BW'(hi); m_en[idx] = en; m_wok[idx] = wok;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input int a, input logic w, input string tag);
    logic exp;
    acc_valid = 1; acc_addr = AW'(a); acc_write = w;
    exp = model(AW'(a), w);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic sweep(input int first, input int last, input string tag);
    for (int a = first; a <= last; a++) begin
      access(a, 1'b0, tag);
      access(a, 1'b1, tag);
    end
    acc_valid = 0;
    @(negedge clk);
    check(1'b0, "R2 idle");
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_en[i] = 0; m_wok[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(1'b0, "R1 reset low");
    // R5: nothing enabled after reset
    access(0, 1'b0, "R1/R5 empty table read");
    access(8, 1'b1, "R1/R5 empty table write");
    acc_valid = 0;
    @(negedge clk);
    check(1'b0, "R2 idle after access");

    // R3 R4 R6: 0..7 read-only; R8 empty window; R9 disabled window
    set_win(0, 0, 0, 1, 0);
    access(7, 1'b0, "R10 immediate use");
    set_win(1, 2, 4, 1, 1);
    set_win(2, 6, 5, 1, 1);
    set_win(3, 8, 9, 0, 1);
    sweep(0, 95, "R3/R4/R5/R6/R8/R9 low sweep");

    // R7 overlap: read-only 16..31 with writable 24..39
    set_win(0, 2, 3, 1, 0);
    set_win(1, 3, 4, 1, 1);
    set_win(3, 8, 9, 1, 0);
    sweep(0, 95, "R6/R7/R9 overlap sweep");

    // R4 end padding around 0x13F888
    set_win(0, 'h13F800 >> 3, 'h13F888 >> 3, 1, 1);
    sweep('h13F7F0, 'h13F89F, "R3/R4 high window");

    // Top of address space
    set_win(1, 'hFFFFF, 'hFFFFF, 1, 0);
    sweep('h7FFFE8, 'h7FFFFF, "R4/R6 top block");

    // R9 disabling removes effect
    set_win(0, 'h13F800 >> 3, 'h13F888 >> 3, 0, 1);
    access('h13F880, 1'b0, "R9 disabled window");
    acc_valid = 0;
    @(negedge clk);
    check(1'b0, "R2 final idle");

    // R1 reset again mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < NW; i++) m_en[i] = 0;
    access('h7FFFFF, 1'b0, "R1 reset clears windows");
    acc_valid = 0;
    @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule